// File: doc/BRIEF.md
# Runtime-Configurable SPI Master

This block is a full-duplex serial peripheral interface master. A host sets up the clock polarity, clock phase, bit order, frame width (8 or 16 bits) and a power-of-two clock prescaler. It then writes a transmit word with a one-cycle strobe. The block frames the transfer with an active-low chip select and generates the serial clock. On each serial clock cycle it shifts one bit out on MOSI and captures one bit from MISO. When the frame ends it presents the received word and raises a completion flag.

The host can take over the chip-select line through a separate strobe, for example to keep a slave selected across several frames. Setup writes that arrive while a frame is running are dropped. A transmit write that arrives while a frame is running is rejected and recorded in a collision flag, and the running frame is left untouched. The host-side reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `spi_master_ctl`

## Requirements
- R1: Whenever no frame is running, `sck` rests at the configured polarity bit `cfg_cpol` (0 means idle low, 1 means idle high), including after the end of every frame.
- R2: With `cfg_cpha`=0, the first data bit is on `mosi` before the first `sck` edge, `miso` is sampled on each leading edge and `mosi` changes on trailing edges. With `cfg_cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R3: With `cfg_cpol`=1 and `cfg_cpha`=1, `mosi` changes only on falling `sck` edges and `miso` is captured on rising edges.
- R4: A prescaler code n (0..7) makes every `sck` half period last 2^n system clocks, so the divide ratio is 2^(n+1) (2 to 256). A frame of W bits keeps `busy` high for exactly (2W+1)*2^n clocks.
- R5: `cfg_wide`=0 gives 8-bit frames that use `tx_data[7:0]`, and `rx_data[15:8]` reads zero. `cfg_wide`=1 gives 16-bit frames.
- R6: `cfg_lsb_first`=0 sends and receives the most significant bit first. `cfg_lsb_first`=1 sends and receives bit 0 first.
- R7: A W-bit frame has exactly W `sck` cycles (2W edges). Each cycle moves one bit out on `mosi` and one bit in from `miso`, and the assembled word appears on `rx_data` when `busy` falls.
- R8: When software control is off (`cs_sw_en`=0), `cs_n` is low exactly while `busy` is high. When software control is on, `cs_n` follows the written `cs_sw_lvl`, during frames as well.
- R9: `done` rises in the cycle `busy` falls at the end of a frame and is cleared when the next frame starts.
- R10: A `tx_we` while `busy` is high sets `wcol` and does not change the running frame's transmitted or received data. `wcol` clears when the next frame starts.
- R11: A `cfg_we` while `busy` is high is ignored: polarity, phase, width, order and prescaler stay as they were.
- R12: After reset, `busy`, `done` and `wcol` are 0, `cs_n` is 1, `sck` is 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe (ignored while busy) |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wide | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| cfg_presc | input | 3 | Half period of 2^n system clocks |
| cs_we | input | 1 | Chip-select control write strobe |
| cs_sw_en | input | 1 | 1: software drives chip select |
| cs_sw_lvl | input | 1 | Chip-select level under software control |
| tx_we | input | 1 | Transmit write; starts a frame when idle |
| tx_data | input | 16 | Transmit word |
| miso | input | 1 | Serial data from the slave |
| rx_data | output | 16 | Last received word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame completed |
| wcol | output | 1 | Transmit write collided with a running frame |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench uses the default build: frames of up to 16 bits with an 8-bit narrow mode, and a 3-bit prescaler code. With these values all four clock modes, both bit orders and both frame widths can be run against a behavioural slave in the bench. The prescaler codes run from 0, where `sck` toggles every system clock, up to 7, which gives a divide-by-256 frame, so the exact frame length can be counted at both ends of the range. Collision, setup lockout, software chip select and flag clearing are then exercised on top of that configuration.

// File: rtl/spi_mst_pkg.sv
`timescale 1ns/1ps
package spi_mst_pkg;
  localparam int SPI_PW = 3;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              lsb_first;
    logic              wide;
    logic [SPI_PW-1:0] presc;
  } spi_cfg_t;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_st_t;
endpackage

// File: rtl/spi_mst_cfg.sv
`timescale 1ns/1ps
module spi_mst_cfg
  import spi_mst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              cfg_we_i,
  input  spi_cfg_t          cfg_wdata_i,
  input  logic              cs_we_i,
  input  logic              cs_en_i,
  input  logic              cs_lvl_i,
  output spi_cfg_t          cfg_o,
  output logic              cs_en_o,
  output logic              cs_lvl_o
);
  spi_cfg_t cfg_q, cfg_d;
  logic     cs_en_q, cs_en_d;
  logic     cs_lvl_q, cs_lvl_d;
  logic     cfg_en;

  // setup lockout while a frame is running
  assign cfg_en = cfg_we_i & ~busy_i;

  always_comb begin
    cfg_d    = cfg_q;
    cs_en_d  = cs_en_q;
    cs_lvl_d = cs_lvl_q;
    if (cfg_en) cfg_d = cfg_wdata_i;
    if (cs_we_i) begin
      cs_en_d  = cs_en_i;
      cs_lvl_d = cs_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cs_en_q  <= 1'b0;
      cs_lvl_q <= 1'b1;
    end else begin
      cfg_q    <= cfg_d;
      cs_en_q  <= cs_en_d;
      cs_lvl_q <= cs_lvl_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign cs_en_o  = cs_en_q;
  assign cs_lvl_o = cs_lvl_q;
endmodule

// File: rtl/spi_mst_baud.sv
`timescale 1ns/1ps
module spi_mst_baud #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  localparam int CW = 1 << PW;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;

  assign lim    = (CW'(1) << presc_i) - CW'(1);
  assign tick_o = run_i & (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || tick_o) cnt_d = '0;
    else if (run_i)      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_mst_engine.sv
`timescale 1ns/1ps
module spi_mst_engine
  import spi_mst_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  spi_cfg_t      cfg_i,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [DW-1:0] tx_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          fin_o,
  output logic [DW-1:0] rx_o
);
  localparam int EW = $clog2(2*DW+1);
  localparam int PADW = DW - NW;

  eng_st_t       st_q, st_d;
  logic          sck_q, sck_d;
  logic          mosi_q, mosi_d;
  logic [DW-1:0] tx_sh_q, tx_sh_d;
  logic [DW-1:0] rx_sh_q, rx_sh_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [EW-1:0] ecnt_q, ecnt_d;

  logic [EW-1:0] last_e;
  logic [DW-1:0] rev_full, rx_rev_full, load_w, rx_asm;
  logic [NW-1:0] rev_nar, rx_rev_nar;
  logic          lead, samp, drv, fin;

  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_rev_full
      assign rev_full[g]    = tx_i[DW-1-g];
      assign rx_rev_full[g] = rx_sh_q[DW-1-g];
    end
    for (g = 0; g < NW; g++) begin : g_rev_nar
      assign rev_nar[g]    = tx_i[NW-1-g];
      assign rx_rev_nar[g] = rx_sh_q[NW-1-g];
    end
  endgenerate

  // edge count that ends the frame: two edges per bit
  assign last_e = cfg_i.wide ? EW'(2*DW) : EW'(2*NW);

  // outgoing word aligned so the first bit sits at the top
  always_comb begin
    if (cfg_i.lsb_first)
      load_w = cfg_i.wide ? rev_full : {rev_nar, {PADW{1'b0}}};
    else
      load_w = cfg_i.wide ? tx_i : {tx_i[NW-1:0], {PADW{1'b0}}};
  end

  // first received bit ends up at position W-1
  always_comb begin
    if (cfg_i.lsb_first)
      rx_asm = cfg_i.wide ? rx_rev_full : {{PADW{1'b0}}, rx_rev_nar};
    else
      rx_asm = cfg_i.wide ? rx_sh_q : {{PADW{1'b0}}, rx_sh_q[NW-1:0]};
  end

  always_comb begin
    st_d    = st_q;
    sck_d   = sck_q;
    mosi_d  = mosi_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    rx_d    = rx_q;
    ecnt_d  = ecnt_q;
    fin     = 1'b0;
    lead    = ~ecnt_q[0];
    samp    = 1'b0;
    drv     = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        sck_d = cfg_i.cpol;
        if (start_i) begin
          st_d    = ENG_SHIFT;
          ecnt_d  = '0;
          rx_sh_d = '0;
          if (cfg_i.cpha) begin
            tx_sh_d = load_w;
          end else begin
            tx_sh_d = load_w << 1;
            mosi_d  = load_w[DW-1];
          end
        end
      end
      ENG_SHIFT: begin
        if (tick_i) begin
          if (ecnt_q == last_e) begin
            st_d = ENG_IDLE;
            fin  = 1'b1;
            rx_d = rx_asm;
          end else begin
            sck_d  = ~sck_q;
            ecnt_d = ecnt_q + EW'(1);
            samp   = lead ^ cfg_i.cpha;
            drv    = cfg_i.cpha ? lead : (~lead && (ecnt_q != last_e - EW'(1)));
            if (samp) rx_sh_d = {rx_sh_q[DW-2:0], miso_i};
            if (drv) begin
              mosi_d  = tx_sh_q[DW-1];
              tx_sh_d = tx_sh_q << 1;
            end
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      ecnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      sck_q   <= sck_d;
      mosi_q  <= mosi_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      rx_q    <= rx_d;
      ecnt_q  <= ecnt_d;
    end
  end

  assign busy_o = (st_q == ENG_SHIFT);
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign fin_o  = fin;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_master_ctl.sv
`timescale 1ns/1ps
module spi_master_ctl
  import spi_mst_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [SPI_PW-1:0] cfg_presc,
  input  logic              cs_we,
  input  logic              cs_sw_en,
  input  logic              cs_sw_lvl,
  input  logic              tx_we,
  input  logic [DW-1:0]     tx_data,
  input  logic              miso,
  output logic [DW-1:0]     rx_data,
  output logic              busy,
  output logic              done,
  output logic              wcol,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_core;
  spi_cfg_t   cfg_wdata, cfg_q;
  logic       cs_en_q, cs_lvl_q;
  logic       start, tick, fin;
  logic       done_q, done_d, wcol_q, wcol_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core = rst_pipe_q[1];

  assign cfg_wdata = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first,
                       wide: cfg_wide, presc: cfg_presc};

  spi_mst_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_core),
    .busy_i     (busy),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .cs_we_i    (cs_we),
    .cs_en_i    (cs_sw_en),
    .cs_lvl_i   (cs_sw_lvl),
    .cfg_o      (cfg_q),
    .cs_en_o    (cs_en_q),
    .cs_lvl_o   (cs_lvl_q)
  );

  assign start = tx_we & ~busy;

  spi_mst_baud #(.PW(SPI_PW)) u_baud (
    .clk    (clk),
    .rst_n  (rst_core),
    .run_i  (busy),
    .clr_i  (start),
    .presc_i(cfg_q.presc),
    .tick_o (tick)
  );

  spi_mst_engine #(.DW(DW), .NW(NW)) u_eng (
    .clk    (clk),
    .rst_n  (rst_core),
    .cfg_i  (cfg_q),
    .start_i(start),
    .tick_i (tick),
    .tx_i   (tx_data),
    .miso_i (miso),
    .busy_o (busy),
    .sck_o  (sck),
    .mosi_o (mosi),
    .fin_o  (fin),
    .rx_o   (rx_data)
  );

  always_comb begin
    done_d = done_q;
    wcol_d = wcol_q;
    if (start) begin
      done_d = 1'b0;
      wcol_d = 1'b0;
    end
    if (fin)           done_d = 1'b1;
    if (tx_we && busy) wcol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      done_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      done_q <= done_d;
      wcol_q <= wcol_d;
    end
  end

  assign done = done_q;
  assign wcol = wcol_q;
  assign cs_n = cs_en_q ? cs_lvl_q : ~busy;
endmodule

// File: rtl/spi_master_ctl_chk.sv
`timescale 1ns/1ps
module spi_master_ctl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wcol,
  input logic          tx_we,
  input logic          sck,
  input logic          mosi,
  input logic          cs_n,
  input logic [DW-1:0] rx_data,
  input logic          cpol,
  input logic          cpha,
  input logic          cs_en,
  input logic          fin,
  input logic [6:0]    cfg_bits
);
  // R1: idle clock rests at the polarity level
  a_r1_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

  // R3: in mode 3 data never moves on a rising clock edge
  a_r3_mode3_mosi: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpol && cpha && $rose(sck)) |-> $stable(mosi));

  // R7: received word changes only when a frame ends
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rx_data));

  // R8: automatic chip select tracks the frame
  a_r8_cs_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_en && busy) |-> !cs_n);

  // R9: completion follows the end of a frame, cleared at a start
  a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done);
  a_r9_done_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);

  // R10: write during a frame flags a collision
  a_r10_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && busy) |=> wcol);

  // R11: setup frozen while busy
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_bits));
endmodule

bind spi_master_ctl spi_master_ctl_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core),
  .busy    (busy),
  .done    (done),
  .wcol    (wcol),
  .tx_we   (tx_we),
  .sck     (sck),
  .mosi    (mosi),
  .cs_n    (cs_n),
  .rx_data (rx_data),
  .cpol    (cfg_q.cpol),
  .cpha    (cfg_q.cpha),
  .cs_en   (cs_en_q),
  .fin     (fin),
  .cfg_bits(cfg_q)
);

// File: tb/spi_master_ctl_tb.sv
`timescale 1ns/1ps
module spi_master_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide;
  logic [2:0]  cfg_presc;
  logic        cs_we, cs_sw_en, cs_sw_lvl;
  logic        tx_we;
  logic [15:0] tx_data;
  logic        miso;
  logic [15:0] rx_data;
  logic        busy, done, wcol, sck, mosi, cs_n;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spi_master_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide),
    .cfg_presc(cfg_presc), .cs_we(cs_we), .cs_sw_en(cs_sw_en),
    .cs_sw_lvl(cs_sw_lvl), .tx_we(tx_we), .tx_data(tx_data), .miso(miso),
    .rx_data(rx_data), .busy(busy), .done(done), .wcol(wcol), .sck(sck),
    .mosi(mosi), .cs_n(cs_n)
  );

  // vector: cpol, cpha, lsb_first, wide, presc[2:0], tx[15:0], slave word[15:0]
  localparam bit [38:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h00A5, 16'h003C},
    {1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 16'h004B, 16'h00C3},
    {1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 16'hFF81, 16'h007E},
    {1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 16'h004B, 16'h00D2},
    {1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 16'h0001, 16'h0080},
    {1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 16'h1234, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 16'hF00D, 16'h5A5A},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'd7, 16'h8001, 16'h6C35}
  };

  // behavioural slave
  bit          s_cpol, s_cpha, s_lsb, slv_on;
  int          s_w, s_ti, s_ri, tog;
  logic [15:0] s_out, s_in;

  function automatic int slot(int i);
    return s_lsb ? i : s_w - 1 - i;
  endfunction

  always @(sck) begin
    if (slv_on) begin
      tog++;
      if (sck != s_cpol) begin
        if (!s_cpha) begin
          if (s_ri < s_w) s_in[slot(s_ri)] = mosi;
          s_ri++;
        end else begin
          if (s_ti < s_w) miso = s_out[slot(s_ti)];
          s_ti++;
        end
      end else begin
        if (!s_cpha) begin
          s_ti++;
          if (s_ti < s_w) miso = s_out[slot(s_ti)];
        end else begin
          if (s_ri < s_w) s_in[slot(s_ri)] = mosi;
          s_ri++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input bit cp, input bit ph, input bit lsb,
                         input bit wd, input logic [2:0] ps);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cpol = cp; cfg_cpha = ph; cfg_lsb_first = lsb;
    cfg_wide = wd; cfg_presc = ps;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(input bit cp, input bit ph, input bit lsb, input bit wd,
                        input logic [15:0] tx, input logic [15:0] sw);
    s_cpol = cp; s_cpha = ph; s_lsb = lsb; s_w = wd ? 16 : 8;
    s_out = sw; s_in = '0; s_ti = 0; s_ri = 0; tog = 0;
    slv_on = 1'b1;
    if (!ph) miso = s_out[slot(0)];
    @(negedge clk);
    tx_we = 1'b1; tx_data = tx;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic finish(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    slv_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int          cyc;
    logic [15:0] mask;
    rst_n = 1'b0; cfg_we = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
    cfg_wide = 0; cfg_presc = 0; cs_we = 0; cs_sw_en = 0; cs_sw_lvl = 1;
    tx_we = 0; tx_data = '0; miso = 0; slv_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(busy == 0 && done == 0 && wcol == 0, "R12", "flags after reset",
        {busy, done, wcol}, 0);
    chk(cs_n == 1 && sck == 0, "R12", "cs_n/sck after reset", {cs_n, sck}, 2);
    chk(rx_data == 0, "R12", "rx_data after reset", rx_data, 0);

    // table walk over modes, widths, orders and prescalers
    for (int v = 0; v < 8; v++) begin
      bit cp, ph, lsb, wd;
      logic [2:0]  ps;
      logic [15:0] tx, sw;
      {cp, ph, lsb, wd, ps, tx, sw} = VEC[v];
      mask = wd ? 16'hFFFF : 16'h00FF;
      set_cfg(cp, ph, lsb, wd, ps);
      chk(sck == cp, "R1", "sck idle before frame", sck, cp);
      launch(cp, ph, lsb, wd, tx, sw);
      chk(cs_n == 0, "R8", "cs_n low in auto frame", cs_n, 0);
      if (v > 0) chk(done == 0, "R9", "done cleared at start", done, 0);
      finish(cyc);
      chk(cyc == ((2 * s_w + 1) << ps), "R4", "busy cycles", cyc, (2 * s_w + 1) << ps);
      chk(tog == 2 * s_w, "R7", "sck edge count", tog, 2 * s_w);
      chk(rx_data == (sw & mask), (cp && ph) ? "R3 R7" : "R7",
          "received word (R5 R6)", rx_data, sw & mask);
      chk(s_in == (tx & mask), (cp && ph) ? "R3 R2" : "R2",
          "slave captured word (R5 R6)", s_in, tx & mask);
      chk(done == 1, "R9", "done after frame", done, 1);
      chk(sck == cp && cs_n == 1, "R1", "sck idle / cs_n high after frame",
          {sck, cs_n}, {cp, 1'b1});
    end

    // R10 collision during a frame
    set_cfg(0, 0, 0, 0, 1);
    launch(0, 0, 0, 0, 16'h0096, 16'h0069);
    chk(done == 0, "R9", "done cleared at start (collision test)", done, 0);
    repeat (5) @(negedge clk);
    tx_we = 1'b1; tx_data = 16'h00FF;
    @(negedge clk);
    tx_we = 1'b0;
    chk(wcol == 1, "R10", "wcol set on write while busy", wcol, 1);
    finish(cyc);
    chk(s_in == 16'h0096, "R10", "frame undisturbed (tx)", s_in, 16'h0096);
    chk(rx_data == 16'h0069, "R10", "frame undisturbed (rx)", rx_data, 16'h0069);

    // R11 setup write while busy is ignored
    launch(0, 0, 0, 0, 16'h00C7, 16'h0019);
    chk(wcol == 0, "R10", "wcol cleared at next start", wcol, 0);
    repeat (4) @(negedge clk);
    cfg_we = 1'b1; cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 1; cfg_wide = 1;
    cfg_presc = 0;
    @(negedge clk);
    cfg_we = 1'b0;
    finish(cyc);
    chk(cyc == (17 << 1) - 5, "R11", "prescaler kept", cyc, (17 << 1) - 5);
    repeat (3) @(negedge clk);
    chk(sck == 0, "R11", "polarity kept", sck, 0);
    chk(rx_data == 16'h0019, "R11", "width/order kept", rx_data, 16'h0019);

    // R8 software chip select
    @(negedge clk);
    cs_we = 1'b1; cs_sw_en = 1'b1; cs_sw_lvl = 1'b0;
    @(negedge clk);
    cs_we = 1'b0;
    chk(cs_n == 0, "R8", "software cs low while idle", cs_n, 0);
    cs_we = 1'b1; cs_sw_lvl = 1'b1;
    @(negedge clk);
    cs_we = 1'b0;
    launch(0, 0, 0, 0, 16'h0011, 16'h0022);
    repeat (3) @(negedge clk);
    chk(busy == 1 && cs_n == 1, "R8", "software cs holds high in frame",
        {busy, cs_n}, 2'b11);
    finish(cyc);
    chk(rx_data == 16'h0022, "R7", "frame under software cs", rx_data, 16'h0022);
    cs_we = 1'b1; cs_sw_en = 1'b0;
    @(negedge clk);
    cs_we = 1'b0;
    chk(cs_n == 1, "R8", "auto cs high when idle", cs_n, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule